// File: doc/BRIEF.md
# Supervisor Exception Entry Controller

This block owns the five-bit supervisor status register of a small 16-bit processor and runs the short sequence that moves the core into supervisor mode. Four things start that sequence: reset, a hardware interrupt request, a software system call, and an illegal instruction. An illegal instruction is either an opcode the decoder cannot recognise or a supervisor-only instruction issued in user mode. When an event is accepted, the controller records the cause in the status register. It then writes the interrupted program counter to the memory word addressed by a save-pointer register and loads the program counter from a vector register.

The supervisor bit is also the MMU bypass control. While it is 1, addresses go to memory untranslated. The branch unit sends a return-to-user request, which clears the bit before the next fetch. A freeze bit halts execution until an interrupt request arrives. While the controller is storing the return address and loading the vector, a busy output stalls instruction fetch.

Top module: `sup_entry_ctrl`

## Requirements
- R1: The status output has supervisor at bit 4, soft-interrupt at bit 3, interrupt-enable at bit 2, freeze at bit 1 and illegal at bit 0. While reset is asserted, and for the first clock cycle after it is released, the status reads 5'b10000, busy is 1, pc_load_o is 1 and pc_new_o is 0. After that cycle busy returns to 0.
- R2: When more than one event arrives in the same cycle, illegal is taken first, then syscall, then the hardware interrupt. On entry, the soft-interrupt bit is set only for a syscall and the illegal bit is set only for an illegal instruction.
- R3: A hardware interrupt is accepted only when interrupt-enable is 1 and the cycle is an instruction boundary (or the core is frozen). Otherwise it starts no entry and leaves busy at 0.
- R4: In the cycle after an event is accepted, the status shows supervisor 1, interrupt-enable 0 and freeze 0.
- R5: The first busy cycle after acceptance drives a store of the program counter sampled at acceptance to the save-pointer address. The second busy cycle loads the vector value as the new PC. Busy lasts exactly these two cycles.
- R6: A supervisor-only instruction strobe causes an illegal-instruction entry in user mode. In supervisor mode it has no effect.
- R7: halted_o follows the freeze bit. An interrupt request while frozen clears freeze in the next cycle. If interrupt-enable is 1, the request also starts an entry.
- R8: A return-to-user request while not busy clears the supervisor bit in the next cycle and leaves the other bits unchanged. An event accepted in the same cycle takes precedence over it.
- R9: A status write loads all five bits in the next cycle when not busy. It is ignored while busy, and ignored in a cycle that has an accepted event or a return-to-user request.
- R10: Syscall, illegal and status-write inputs have no effect while busy. No second entry follows the current one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_i | input | 1 | Hardware interrupt request (level) |
| syscall_i | input | 1 | Software call strobe from decode |
| illegal_i | input | 1 | Undecodable opcode strobe |
| priv_op_i | input | 1 | Supervisor-only instruction decoded |
| boundary_i | input | 1 | Current cycle is an instruction boundary |
| pc_i | input | 16 | Current program counter |
| vector_i | input | 16 | Exception vector register value |
| save_ptr_i | input | 16 | Return-address save pointer register value |
| user_jump_i | input | 1 | Jump-to-user request from the branch unit |
| sr_wr_i | input | 1 | Status register write strobe |
| sr_wdata_i | input | 5 | Status register write data |
| st_wr_o | output | 1 | Return PC store request |
| st_addr_o | output | 16 | Store address |
| st_data_o | output | 16 | Store data (return PC) |
| pc_load_o | output | 1 | Load new PC |
| pc_new_o | output | 16 | New PC value |
| busy_o | output | 1 | Entry in progress, stall fetch |
| sup_mode_o | output | 1 | Supervisor mode, MMU bypass |
| halted_o | output | 1 | Freeze active |
| status_o | output | 5 | Status register contents |

## Verification
When an event is accepted at a clock edge, the status change and the store request appear one cycle later. The vector load comes one cycle after that, and busy is clear again on the third cycle. Status writes and return-to-user requests show on the status output one cycle after they are presented. The bench drives inputs on the falling edge and then samples each of these cycles on the following falling edges, in turn. Ignored stimuli are checked at the first falling edge at which an effect would have appeared.

// File: rtl/sup_entry_pkg.sv
// Package: shared encodings for the supervisor entry controller.
// Assumes a five-bit status register; bit positions are fixed by the brief.
package sup_entry_pkg;

    localparam int STAT_W  = 5;
    localparam int BIT_SUP = 4;
    localparam int BIT_SOFT = 3;
    localparam int BIT_IE  = 2;
    localparam int BIT_FRZ = 1;
    localparam int BIT_ILL = 0;

    localparam logic [STAT_W-1:0] STAT_RESET = 5'b10000;

    typedef enum logic [1:0] {
        CAUSE_NONE = 2'd0,
        CAUSE_ILL  = 2'd1,
        CAUSE_SYS  = 2'd2,
        CAUSE_IRQ  = 2'd3
    } cause_e;

    typedef enum logic [1:0] {
        ST_BOOT  = 2'd0,
        ST_IDLE  = 2'd1,
        ST_STORE = 2'd2,
        ST_VECT  = 2'd3
    } seq_state_e;

endpackage

// File: rtl/sup_event_arb.sv
// Module: sup_event_arb
// Picks at most one exception cause per cycle: illegal, then syscall, then
// hardware interrupt. Assumes strobes are only meaningful while idle.
module sup_event_arb
    import sup_entry_pkg::*;
(
    input  logic   idle_i,
    input  logic   illegal_i,
    input  logic   priv_op_i,
    input  logic   syscall_i,
    input  logic   irq_i,
    input  logic   boundary_i,
    input  logic   sup_i,
    input  logic   ie_i,
    input  logic   frz_i,
    output logic   take_o,
    output cause_e cause_o
);

    logic ill_ev;
    logic irq_ev;

    // Qualify raw requests into candidate events.
    always_comb begin
        ill_ev = illegal_i | (priv_op_i & ~sup_i);
        irq_ev = irq_i & ie_i & (boundary_i | frz_i);
    end

    // Fixed-priority selection.
    always_comb begin
        cause_o = CAUSE_NONE;
        if (idle_i) begin
            if (ill_ev)         cause_o = CAUSE_ILL;
            else if (syscall_i) cause_o = CAUSE_SYS;
            else if (irq_ev)    cause_o = CAUSE_IRQ;
        end
        take_o = (cause_o != CAUSE_NONE);
    end

endmodule

// File: rtl/sup_status_reg.sv
// Module: sup_status_reg
// Holds the five status bits. Updates only while idle, with precedence
// entry > return-to-user > software write > wake from freeze.
module sup_status_reg
    import sup_entry_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idle_i,
    input  logic              take_i,
    input  cause_e            cause_i,
    input  logic              user_jump_i,
    input  logic              sr_wr_i,
    input  logic [STAT_W-1:0] sr_wdata_i,
    input  logic              irq_i,
    output logic [STAT_W-1:0] status_o
);

    logic [STAT_W-1:0] stat_q;
    logic [STAT_W-1:0] stat_d;

    // Next-state selection for the status bits.
    always_comb begin
        stat_d = stat_q;
        if (idle_i) begin
            if (take_i) begin
                stat_d[BIT_SUP]  = 1'b1;
                stat_d[BIT_IE]   = 1'b0;
                stat_d[BIT_FRZ]  = 1'b0;
                stat_d[BIT_SOFT] = (cause_i == CAUSE_SYS);
                stat_d[BIT_ILL]  = (cause_i == CAUSE_ILL);
            end else if (user_jump_i) begin
                stat_d[BIT_SUP] = 1'b0;
            end else if (sr_wr_i) begin
                stat_d = sr_wdata_i;
            end else if (irq_i && stat_q[BIT_FRZ]) begin
                stat_d[BIT_FRZ] = 1'b0;
            end
        end
    end

    // Status register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= STAT_RESET;
        else        stat_q <= stat_d;
    end

    assign status_o = stat_q;

endmodule

// File: rtl/sup_entry_seq.sv
// Module: sup_entry_seq
// Sequencer: boot vector after reset, then per entry a store cycle and a
// vector-load cycle. Captures the PC in the accepting cycle.
module sup_entry_seq
    import sup_entry_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [ADDR_W-1:0] vector_i,
    input  logic [ADDR_W-1:0] save_ptr_i,
    output logic              idle_o,
    output logic              busy_o,
    output logic              st_wr_o,
    output logic [ADDR_W-1:0] st_addr_o,
    output logic [ADDR_W-1:0] st_data_o,
    output logic              pc_load_o,
    output logic [ADDR_W-1:0] pc_new_o
);

    localparam logic [ADDR_W-1:0] BOOT_PC = '0;

    seq_state_e        state_q;
    seq_state_e        state_d;
    logic [ADDR_W-1:0] ret_pc_q;

    // State transitions.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BOOT:  state_d = ST_IDLE;
            ST_IDLE:  if (take_i) state_d = ST_STORE;
            ST_STORE: state_d = ST_VECT;
            ST_VECT:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_BOOT;
        else        state_q <= state_d;
    end

    // Return PC capture at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n)                         ret_pc_q <= '0;
        else if (state_q == ST_IDLE && take_i) ret_pc_q <= pc_i;
    end

    // Output decode from state.
    always_comb begin
        idle_o    = (state_q == ST_IDLE);
        busy_o    = ~idle_o;
        st_wr_o   = (state_q == ST_STORE);
        st_addr_o = st_wr_o ? save_ptr_i : '0;
        st_data_o = st_wr_o ? ret_pc_q : '0;
        pc_load_o = (state_q == ST_BOOT) || (state_q == ST_VECT);
        pc_new_o  = (state_q == ST_VECT) ? vector_i : BOOT_PC;
    end

endmodule

// File: rtl/sup_entry_ctrl.sv
// Module: sup_entry_ctrl (top)
// Supervisor status register plus exception entry sequencing. The
// supervisor bit is exported as the MMU bypass control.
module sup_entry_ctrl
    import sup_entry_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_i,
    input  logic              syscall_i,
    input  logic              illegal_i,
    input  logic              priv_op_i,
    input  logic              boundary_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [ADDR_W-1:0] vector_i,
    input  logic [ADDR_W-1:0] save_ptr_i,
    input  logic              user_jump_i,
    input  logic              sr_wr_i,
    input  logic [4:0]        sr_wdata_i,
    output logic              st_wr_o,
    output logic [ADDR_W-1:0] st_addr_o,
    output logic [ADDR_W-1:0] st_data_o,
    output logic              pc_load_o,
    output logic [ADDR_W-1:0] pc_new_o,
    output logic              busy_o,
    output logic              sup_mode_o,
    output logic              halted_o,
    output logic [4:0]        status_o
);

    logic   idle;
    logic   take;
    cause_e cause;
    logic [STAT_W-1:0] stat;

    sup_event_arb u_arb (
        .idle_i     (idle),
        .illegal_i  (illegal_i),
        .priv_op_i  (priv_op_i),
        .syscall_i  (syscall_i),
        .irq_i      (irq_i),
        .boundary_i (boundary_i),
        .sup_i      (stat[BIT_SUP]),
        .ie_i       (stat[BIT_IE]),
        .frz_i      (stat[BIT_FRZ]),
        .take_o     (take),
        .cause_o    (cause)
    );

    sup_status_reg u_stat (
        .clk         (clk),
        .rst_n       (rst_n),
        .idle_i      (idle),
        .take_i      (take),
        .cause_i     (cause),
        .user_jump_i (user_jump_i),
        .sr_wr_i     (sr_wr_i),
        .sr_wdata_i  (sr_wdata_i),
        .irq_i       (irq_i),
        .status_o    (stat)
    );

    sup_entry_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .take_i     (take),
        .pc_i       (pc_i),
        .vector_i   (vector_i),
        .save_ptr_i (save_ptr_i),
        .idle_o     (idle),
        .busy_o     (busy_o),
        .st_wr_o    (st_wr_o),
        .st_addr_o  (st_addr_o),
        .st_data_o  (st_data_o),
        .pc_load_o  (pc_load_o),
        .pc_new_o   (pc_new_o)
    );

    assign status_o   = stat;
    assign sup_mode_o = stat[BIT_SUP];
    assign halted_o   = stat[BIT_FRZ];

endmodule

// File: rtl/sup_entry_ctrl_chk.sv
// Module: sup_entry_ctrl_chk
// Port-level properties of the entry controller, bound to the top.
module sup_entry_ctrl_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq_i,
    input logic              syscall_i,
    input logic              illegal_i,
    input logic              priv_op_i,
    input logic [ADDR_W-1:0] pc_i,
    input logic [ADDR_W-1:0] save_ptr_i,
    input logic              user_jump_i,
    input logic              st_wr_o,
    input logic [ADDR_W-1:0] st_addr_o,
    input logic [ADDR_W-1:0] st_data_o,
    input logic              pc_load_o,
    input logic              busy_o,
    input logic              sup_mode_o,
    input logic [4:0]        status_o
);

    AST_STORE_THEN_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        st_wr_o |=> (pc_load_o && busy_o)); // R5

    AST_STORE_CARRIES_PC: assert property (@(posedge clk) disable iff (!rst_n)
        st_wr_o |-> (st_data_o == $past(pc_i) && st_addr_o == save_ptr_i)); // R5

    AST_ENTRY_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        st_wr_o |-> (sup_mode_o && !status_o[2] && !status_o[1])); // R4

    AST_VECTOR_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_load_o && !st_wr_o && $past(st_wr_o)) |=> !busy_o); // R5

    AST_USER_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        (user_jump_i && !busy_o && !syscall_i && !illegal_i && !priv_op_i && !irq_i)
            |=> !sup_mode_o); // R8

    AST_SOFT_ILL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        st_wr_o |-> !(status_o[3] && status_o[0])); // R2

endmodule

bind sup_entry_ctrl sup_entry_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_i       (irq_i),
    .syscall_i   (syscall_i),
    .illegal_i   (illegal_i),
    .priv_op_i   (priv_op_i),
    .pc_i        (pc_i),
    .save_ptr_i  (save_ptr_i),
    .user_jump_i (user_jump_i),
    .st_wr_o     (st_wr_o),
    .st_addr_o   (st_addr_o),
    .st_data_o   (st_data_o),
    .pc_load_o   (pc_load_o),
    .busy_o      (busy_o),
    .sup_mode_o  (sup_mode_o),
    .status_o    (status_o)
);

// File: tb/sup_entry_ctrl_test.sv
// Bench: directed scenarios for sup_entry_ctrl, one task each.
module sup_entry_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq_i = 1'b0, syscall_i = 1'b0, illegal_i = 1'b0, priv_op_i = 1'b0;
    logic        boundary_i = 1'b0, user_jump_i = 1'b0, sr_wr_i = 1'b0;
    logic [4:0]  sr_wdata_i = 5'd0;
    logic [15:0] pc_i = 16'h0, vector_i = 16'h0, save_ptr_i = 16'h0;
    logic        st_wr_o, pc_load_o, busy_o, sup_mode_o, halted_o;
    logic [15:0] st_addr_o, st_data_o, pc_new_o;
    logic [4:0]  status_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    sup_entry_ctrl uut (
        .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .syscall_i(syscall_i),
        .illegal_i(illegal_i), .priv_op_i(priv_op_i), .boundary_i(boundary_i),
        .pc_i(pc_i), .vector_i(vector_i), .save_ptr_i(save_ptr_i),
        .user_jump_i(user_jump_i), .sr_wr_i(sr_wr_i), .sr_wdata_i(sr_wdata_i),
        .st_wr_o(st_wr_o), .st_addr_o(st_addr_o), .st_data_o(st_data_o),
        .pc_load_o(pc_load_o), .pc_new_o(pc_new_o), .busy_o(busy_o),
        .sup_mode_o(sup_mode_o), .halted_o(halted_o), .status_o(status_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_in();
        irq_i = 0; syscall_i = 0; illegal_i = 0; priv_op_i = 0;
        boundary_i = 0; user_jump_i = 0; sr_wr_i = 0;
    endtask

    task automatic wr_stat(input logic [4:0] v);
        sr_wr_i = 1; sr_wdata_i = v;
        @(negedge clk); clear_in();
        chk("R9 status write", status_o, v);
    endtask

    // Walks the two busy cycles of an accepted entry; inputs already driven.
    task automatic expect_entry(input string tag, input logic [4:0] stat,
                                input logic [15:0] pc, input logic [15:0] ptr,
                                input logic [15:0] vec);
        @(negedge clk); clear_in();
        chk({tag, " R4 status"}, status_o, stat);
        chk({tag, " R5 store"}, {st_wr_o, busy_o}, 2'b11);
        chk({tag, " R5 addr"}, st_addr_o, ptr);
        chk({tag, " R5 data"}, st_data_o, pc);
        @(negedge clk);
        chk({tag, " R5 vector"}, {pc_load_o, st_wr_o}, 2'b10);
        chk({tag, " R5 newpc"}, pc_new_o, vec);
        @(negedge clk);
        chk({tag, " R5 busy end"}, busy_o, 1'b0);
    endtask

    task automatic t_reset();
        chk("R1 reset status", status_o, 5'b10000);
        chk("R1 reset boot", {busy_o, pc_load_o, pc_new_o}, {2'b11, 16'h0});
        rst_n = 1;
        chk("R1 boot cycle", {busy_o, pc_load_o}, 2'b11);
        @(negedge clk);
        chk("R1 idle after boot", {busy_o, pc_load_o}, 2'b00);
    endtask

    task automatic t_syscall();
        pc_i = 16'h1234; save_ptr_i = 16'h0100; vector_i = 16'h0800;
        syscall_i = 1;
        expect_entry("syscall", 5'b11000, 16'h1234, 16'h0100, 16'h0800);
    endtask

    task automatic t_irq_gate();
        wr_stat(5'b10000);
        irq_i = 1; boundary_i = 1;
        @(negedge clk); clear_in();
        chk("R3 irq masked", {busy_o, status_o}, {1'b0, 5'b10000});
        wr_stat(5'b10100);
        irq_i = 1; boundary_i = 0;
        @(negedge clk);
        chk("R3 irq off boundary", {busy_o, status_o}, {1'b0, 5'b10100});
        pc_i = 16'h0042; boundary_i = 1;
        expect_entry("irq", 5'b10000, 16'h0042, 16'h0100, 16'h0800);
    endtask

    task automatic t_priority();
        wr_stat(5'b10100);
        illegal_i = 1; syscall_i = 1; irq_i = 1; boundary_i = 1; pc_i = 16'h0AAA;
        expect_entry("R2 ill first", 5'b10001, 16'h0AAA, 16'h0100, 16'h0800);
        wr_stat(5'b10100);
        syscall_i = 1; irq_i = 1; boundary_i = 1; pc_i = 16'h0BBB;
        expect_entry("R2 sys over irq", 5'b11000, 16'h0BBB, 16'h0100, 16'h0800);
    endtask

    task automatic t_priv();
        wr_stat(5'b10100);
        priv_op_i = 1;
        @(negedge clk); clear_in();
        chk("R6 priv in sup ignored", {busy_o, status_o}, {1'b0, 5'b10100});
        wr_stat(5'b00100);
        chk("R6 user mode", sup_mode_o, 1'b0);
        priv_op_i = 1; pc_i = 16'h2000; save_ptr_i = 16'h0300; vector_i = 16'h0900;
        expect_entry("R6 priv in user", 5'b10001, 16'h2000, 16'h0300, 16'h0900);
    endtask

    task automatic t_freeze();
        wr_stat(5'b10010);
        chk("R7 halted", halted_o, 1'b1);
        irq_i = 1;
        @(negedge clk); clear_in();
        chk("R7 wake no entry", {busy_o, halted_o, status_o}, {2'b00, 5'b10000});
        wr_stat(5'b10110);
        irq_i = 1; boundary_i = 0; pc_i = 16'h3000;
        expect_entry("R7 wake entry", 5'b10000, 16'h3000, 16'h0300, 16'h0900);
    endtask

    task automatic t_user_jump();
        wr_stat(5'b10101);
        user_jump_i = 1;
        @(negedge clk); clear_in();
        chk("R8 return to user", status_o, 5'b00101);
        user_jump_i = 1; syscall_i = 1; pc_i = 16'h4000;
        expect_entry("R8 event wins", 5'b11000, 16'h4000, 16'h0300, 16'h0900);
        wr_stat(5'b10100);
        user_jump_i = 1; sr_wr_i = 1; sr_wdata_i = 5'b11111;
        @(negedge clk); clear_in();
        chk("R9 write loses to return", status_o, 5'b00100);
    endtask

    task automatic t_busy_ignore();
        wr_stat(5'b10100);
        syscall_i = 1; pc_i = 16'h5000;
        @(negedge clk); clear_in();
        syscall_i = 1; illegal_i = 1; sr_wr_i = 1; sr_wdata_i = 5'b00010;
        @(negedge clk); clear_in();
        chk("R10 status held in busy", {pc_load_o, status_o}, {1'b1, 5'b11000});
        @(negedge clk);
        chk("R10 no second entry", {busy_o, st_wr_o, status_o}, {2'b00, 5'b11000});
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_syscall();
        t_irq_gate();
        t_priority();
        t_priv();
        t_freeze();
        t_user_jump();
        t_busy_ignore();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule